// File: doc/BRIEF.md
# Command-Queued I2C Bus Master

This block is an I2C bus master driven by a small queue of commands. Each queued word is an 11-bit value. Bits [10:8] hold an opcode and bits [7:0] hold a data byte. The opcodes do four things: open a transfer with START and an address byte, transmit a byte, receive a byte, or close with STOP. The engine waits for a free bus and then for a programmable settling delay. It drives the open-drain SCL and SDA controls and samples the lines to read ACK bits and to detect lost arbitration. Received bytes go into a separate 4-entry queue that the host pops.

SCL timing is built from a prescaler and two phase counts, one for the low phase and one for the high phase. The engine chooses ACK or NACK for each received byte by looking at the next queued command. It can close a transfer by itself when the queue runs dry. Sticky flags report a refused byte, lost arbitration, a bad command and a completed STOP.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both line controls are released (`scl_oe`=0, `sda_oe`=0), `busy`=0, all four flags are 0, `rx_valid`=0 and `cmd_ready`=1.
- R2: A transfer starts only when all of these hold: `enable`=1, `bus_idle`=1, the command queue is non-empty, and either `mreq_en`=0 or `mreq`=1.
- R3: Once `busy` rises, SDA is first pulled low (SCL still released) after exactly (`clk_lo`+1)×(`prescale`+1) clocks. This is the START condition, and it is followed by the 8 bits of the START command's data byte, most significant bit first.
- R4: A receive (opcode 1) byte is answered with ACK (SDA low) only when the next queued command is also a receive. Otherwise it is answered with NACK. Received bytes appear on `rx_data` in arrival order, and a shown byte stays until `rx_pop`.
- R5: A START command (opcode 4) that follows a byte inside a transfer produces a repeated START with no STOP before it.
- R6: If the queue is empty after a byte and `autostop_en`=1, the engine issues STOP and goes idle. If `autostop_en`=0, it holds SCL low (`scl_oe`=1) and waits for more commands.
- R7: If `enable` drops during a transfer, the engine still executes every queued command and then issues STOP before going idle.
- R8: A NACK received on an address or transmit byte (opcode 0) sets `nack_flag`, discards all queued commands, and ends with STOP.
- R9: If SDA reads low at the end of an SCL high phase while the engine is sending a 1 bit, `arb_flag` is set, both lines are released at once, the engine goes idle, and the command queue is emptied.
- R10: Opcodes 3, 5, 6 and 7 set `cmd_err_flag` and are dropped without any bus activity. A transmit, receive or STOP command at the queue head while idle is also flagged and dropped.
- R11: With no clock stretching, each SCL high phase of a data bit lasts (`clk_hi`+1)×(`prescale`+1) clocks, and SDA does not change while SCL is released within a bit.
- R12: `stop_flag` is set when an issued STOP completes, and `busy` is 0 in that cycle. All flags stay set until a `flag_clr` pulse.
- R13: `cmd_ready` is 0 when the command queue holds 4 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Master enable |
| autostop_en | input | 1 | Issue STOP when the queue empties |
| mreq_en | input | 1 | Gate starts on `mreq` |
| mreq | input | 1 | External start request |
| bus_idle | input | 1 | Bus reported free |
| prescale | input | PRE_W | Tick period minus one, in clocks |
| clk_lo | input | CNT_W | SCL low count (ticks minus one) |
| clk_hi | input | CNT_W | SCL high count (ticks minus one) |
| cmd_valid | input | 1 | Push a command |
| cmd_data | input | 11 | {opcode[2:0], data[7:0]} |
| cmd_ready | output | 1 | Command queue not full |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Oldest received byte |
| rx_pop | input | 1 | Consume `rx_data` |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| flag_clr | input | 1 | Clear all flags |
| nack_flag | output | 1 | Unexpected NACK |
| arb_flag | output | 1 | Arbitration lost |
| cmd_err_flag | output | 1 | Bad command |
| stop_flag | output | 1 | STOP completed |
| busy | output | 1 | Transfer in progress |

## Verification
The bench uses the default parameters: 4-deep command and receive queues, a 4-bit prescaler and 8-bit phase counts. It drives `prescale`=1, `clk_lo`=3 and `clk_hi`=2, which puts the settling wait at 8 clocks and an SCL high phase at 6 clocks. With these values one byte takes roughly 130 clocks. That keeps full transfers short enough for one bench to cover queue-full back-pressure, five-command repeated-START sequences, drain on disable, the auto-stop choice and flushes after NACK or lost arbitration. The slave model on the bus records every written byte and every ACK the master gives on reads.

// File: rtl/i2cm_pkg.sv
// Shared constants and state encoding for the command-queued I2C master.
package i2cm_pkg;
    localparam int CMD_W = 11;
    localparam logic [2:0] OP_TX    = 3'd0;
    localparam logic [2:0] OP_RX    = 3'd1;
    localparam logic [2:0] OP_STOP  = 3'd2;
    localparam logic [2:0] OP_START = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_WAIT, S_START, S_BLO, S_BHI, S_DISP,
        S_RSLO, S_RSHI, S_PLO, S_PHI, S_PEND
    } state_e;
endpackage

// File: rtl/i2cm_fifo.sv
// Synchronous FIFO with flush and a show-ahead head output.
// Assumes push is ignored when full and pop is ignored when empty.
module i2cm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr, rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign wr    = push && !full;
    assign rd    = pop && !empty;
    assign dout  = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(wr) - CW'(rd);
        end
    end
endmodule

// File: rtl/i2cm_phase_timer.sv
// Phase timer: pulses done once every (cnt+1)*(pre+1) clocks, then wraps.
// Assumes restart holds it at zero and stall freezes it (clock stretching).
module i2cm_phase_timer #(
    parameter int PRE_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             stall,
    input  logic [PRE_W-1:0] pre,
    input  logic [CNT_W-1:0] cnt,
    output logic             done
);
    logic [PRE_W-1:0] pc;
    logic [CNT_W-1:0] qc;

    assign done = !restart && !stall && (pc == pre) && (qc == cnt);

    // Prescaler and phase counters.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pc <= '0;
            qc <= '0;
        end else if (!stall) begin
            if (pc == pre) begin
                pc <= '0;
                qc <= (qc == cnt) ? '0 : qc + 1'b1;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_master.sv
// Command-queued I2C master. It pops {opcode, byte} words and drives
// open-drain SCL/SDA enables. Assumes scl_in/sda_in are already
// synchronised and that bus_idle comes from an external bus monitor.
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int RX_DEPTH  = 4,
    parameter int PRE_W     = 4,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             autostop_en,
    input  logic             mreq_en,
    input  logic             mreq,
    input  logic             bus_idle,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] clk_lo,
    input  logic [CNT_W-1:0] clk_hi,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_data,
    output logic             cmd_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    input  logic             rx_pop,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             flag_clr,
    output logic             nack_flag,
    output logic             arb_flag,
    output logic             cmd_err_flag,
    output logic             stop_flag,
    output logic             busy
);
    state_e st, st_n;
    logic [7:0] sh, sh_n;
    logic [3:0] idx, idx_n;
    logic is_rx, isrx_n, ack_r, ack_n;
    logic cmd_pop, cmd_flush, cmd_empty, cmd_full, rx_push, rx_empty, rx_full;
    logic set_nack, set_arb, set_err, set_stop;
    logic [CMD_W-1:0] head;
    logic [2:0] hop;
    logic [7:0] hdata;
    logic tmr_done, tmr_restart, tmr_stall, start_ok, drv_bit, in_bit;
    logic [CNT_W-1:0] phase_cnt;

    assign hop   = head[10:8];
    assign hdata = head[7:0];

    i2cm_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .flush(cmd_flush), .push(cmd_valid),
        .din(cmd_data), .pop(cmd_pop), .dout(head), .empty(cmd_empty), .full(cmd_full)
    );

    i2cm_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(rx_push),
        .din({sh[6:0], sda_in}), .pop(rx_pop), .dout(rx_data), .empty(rx_empty), .full(rx_full)
    );

    i2cm_phase_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .stall(tmr_stall),
        .pre(prescale), .cnt(phase_cnt), .done(tmr_done)
    );

    assign cmd_ready = !cmd_full;
    assign rx_valid  = !rx_empty;
    assign busy      = (st != S_IDLE);
    assign in_bit    = (st == S_BLO) || (st == S_BHI);
    assign start_ok  = enable && bus_idle && !cmd_empty && (!mreq_en || mreq);
    assign drv_bit   = (idx == 4'd8) ? (is_rx && ack_r) : (!is_rx && !sh[7]);

    // Line drive decoded from the phase state.
    always_comb begin
        scl_oe = (st == S_BLO) || (st == S_DISP) || (st == S_RSLO) || (st == S_PLO);
        case (st)
            S_START, S_PLO, S_PHI: sda_oe = 1'b1;
            S_BLO, S_BHI:          sda_oe = drv_bit;
            default:               sda_oe = 1'b0;
        endcase
    end

    // Timer control: phase length, stretch hold and restart.
    always_comb begin
        phase_cnt   = ((st == S_WAIT) || (st == S_BLO) || (st == S_RSLO) || (st == S_PLO)) ? clk_lo : clk_hi;
        tmr_stall   = !scl_in && ((st == S_START) || (st == S_BHI) || (st == S_RSHI) ||
                                  (st == S_PHI) || (st == S_PEND));
        tmr_restart = (st == S_IDLE) || (st == S_DISP);
    end

    // Next-state, command dispatch and bit-level sequencing.
    always_comb begin
        st_n = st; sh_n = sh; idx_n = idx; isrx_n = is_rx; ack_n = ack_r;
        cmd_pop = 1'b0; cmd_flush = 1'b0; rx_push = 1'b0;
        set_nack = 1'b0; set_arb = 1'b0; set_err = 1'b0; set_stop = 1'b0;
        case (st)
            S_IDLE: if (start_ok) begin
                cmd_pop = 1'b1;
                if (hop == OP_START) begin
                    sh_n = hdata; isrx_n = 1'b0; st_n = S_WAIT;
                end else begin
                    set_err = 1'b1;
                end
            end
            S_WAIT:  if (tmr_done) st_n = S_START;
            S_START: if (tmr_done) begin idx_n = '0; st_n = S_BLO; end
            S_BLO:   if (tmr_done) st_n = S_BHI;
            S_BHI: if (tmr_done) begin
                if (idx == 4'd8) begin
                    if (!is_rx && sda_in) begin
                        set_nack = 1'b1; cmd_flush = 1'b1; st_n = S_PLO;
                    end else begin
                        st_n = S_DISP;
                    end
                end else if (!is_rx && sh[7] && !sda_in) begin
                    set_arb = 1'b1; cmd_flush = 1'b1; st_n = S_IDLE;
                end else begin
                    sh_n = {sh[6:0], sda_in}; idx_n = idx + 4'd1; st_n = S_BLO;
                    if (idx == 4'd7 && is_rx) begin
                        rx_push = 1'b1;
                        ack_n   = !cmd_empty && (hop == OP_RX);
                    end
                end
            end
            S_DISP: begin
                if (cmd_empty) begin
                    if (autostop_en || !enable) st_n = S_PLO;
                end else begin
                    case (hop)
                        OP_TX:    begin cmd_pop = 1'b1; sh_n = hdata; isrx_n = 1'b0; idx_n = '0; st_n = S_BLO; end
                        OP_RX:    if (!rx_full) begin cmd_pop = 1'b1; isrx_n = 1'b1; idx_n = '0; st_n = S_BLO; end
                        OP_START: begin cmd_pop = 1'b1; sh_n = hdata; isrx_n = 1'b0; st_n = S_RSLO; end
                        OP_STOP:  begin cmd_pop = 1'b1; st_n = S_PLO; end
                        default:  begin cmd_pop = 1'b1; set_err = 1'b1; end
                    endcase
                end
            end
            S_RSLO: if (tmr_done) st_n = S_RSHI;
            S_RSHI: if (tmr_done) st_n = S_START;
            S_PLO:  if (tmr_done) st_n = S_PHI;
            S_PHI:  if (tmr_done) st_n = S_PEND;
            S_PEND: if (tmr_done) begin set_stop = 1'b1; st_n = S_IDLE; end
            default: st_n = S_IDLE;
        endcase
    end

    // Engine registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; sh <= '0; idx <= '0; is_rx <= 1'b0; ack_r <= 1'b0;
        end else begin
            st <= st_n; sh <= sh_n; idx <= idx_n; is_rx <= isrx_n; ack_r <= ack_n;
        end
    end

    // Sticky flags: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack_flag <= 1'b0; arb_flag <= 1'b0; cmd_err_flag <= 1'b0; stop_flag <= 1'b0;
        end else begin
            nack_flag    <= (nack_flag    && !flag_clr) || set_nack;
            arb_flag     <= (arb_flag     && !flag_clr) || set_arb;
            cmd_err_flag <= (cmd_err_flag && !flag_clr) || set_err;
            stop_flag    <= (stop_flag    && !flag_clr) || set_stop;
        end
    end
endmodule

// File: rtl/i2cm_checker.sv
// Protocol checker for the command-queued I2C master, bound to the top.
module i2cm_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic bus_idle,
    input logic enable,
    input logic in_bit,
    input logic arb_flag,
    input logic nack_flag,
    input logic stop_flag,
    input logic rx_valid,
    input logic rx_pop
);
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_idle && enable));
    // R4
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_pop |=> rx_valid);
    // R8
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_flag) |-> scl_oe && sda_oe);
    // R9
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_flag) |-> !scl_oe && !sda_oe && !busy);
    // R11
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_bit && !scl_oe && $past(in_bit && !scl_oe) |-> $stable(sda_oe));
    // R12
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> !busy);
endmodule

bind i2c_cmd_master i2cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .bus_idle(bus_idle), .enable(enable), .in_bit(in_bit), .arb_flag(arb_flag),
    .nack_flag(nack_flag), .stop_flag(stop_flag), .rx_valid(rx_valid), .rx_pop(rx_pop)
);

// File: tb/i2c_cmd_master_test.sv
// Directed bench for i2c_cmd_master with a behavioural I2C slave on the bus.
module i2c_cmd_master_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic enable = 1'b1, autostop_en = 1'b0, mreq_en = 1'b0, mreq = 1'b0, bus_idle = 1'b1;
    logic [3:0] prescale = 4'd1;
    logic [7:0] clk_lo = 8'd3, clk_hi = 8'd2;
    logic cmd_valid = 1'b0, rx_pop = 1'b0, flag_clr = 1'b0;
    logic [10:0] cmd_data = '0;
    logic cmd_ready, rx_valid, scl_oe, sda_oe, scl_in, sda_in;
    logic nack_flag, arb_flag, cmd_err_flag, stop_flag, busy;
    logic [7:0] rx_data;
    logic slv_sda = 1'b0, rival = 1'b0, force_nack = 1'b0, clr_req = 1'b0;
    int nchk = 0, nfail = 0;

    assign scl_in = !scl_oe;
    assign sda_in = !(sda_oe || slv_sda || rival);

    always #10 clk = ~clk;

    i2c_cmd_master uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .autostop_en(autostop_en),
        .mreq_en(mreq_en), .mreq(mreq), .bus_idle(bus_idle), .prescale(prescale),
        .clk_lo(clk_lo), .clk_hi(clk_hi), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in),
        .flag_clr(flag_clr), .nack_flag(nack_flag), .arb_flag(arb_flag),
        .cmd_err_flag(cmd_err_flag), .stop_flag(stop_flag), .busy(busy)
    );

    // Behavioural slave at 7-bit address 0x28; read data is 0xC0 + n.
    localparam logic [6:0] SADDR = 7'h28;
    localparam int SL_IDLE = 0, SL_ADDR = 1, SL_WR = 2, SL_RD = 3;
    int sst = SL_IDLE, bc = 0, wr_n = 0, rd_n = 0, ld_n = 0, starts = 0, stops = 0;
    logic [7:0] ssh = '0, tx = '0;
    logic [7:0] wr_b [16];
    logic rd_ack [16];
    logic rdmode = 1'b0, last_ack = 1'b0, p_scl = 1'b1, p_sda = 1'b1;

    always @(negedge clk) begin
        if (clr_req) begin wr_n = 0; rd_n = 0; ld_n = 0; starts = 0; stops = 0; end
        if (p_scl && scl_in && p_sda && !sda_in) begin
            starts++; sst = SL_ADDR; bc = 0; slv_sda = 1'b0;
        end else if (p_scl && scl_in && !p_sda && sda_in) begin
            stops++; sst = SL_IDLE; slv_sda = 1'b0;
        end else if (!p_scl && scl_in && sst != SL_IDLE) begin
            if (bc < 8) ssh = {ssh[6:0], sda_in};
            else if (sst == SL_RD) begin
                last_ack = !sda_in;
                if (rd_n < 16) rd_ack[rd_n] = !sda_in;
                rd_n++;
            end
            bc++;
        end else if (p_scl && !scl_in && sst != SL_IDLE) begin
            if (bc == 8) begin
                if (sst == SL_ADDR) begin
                    if (ssh[7:1] == SADDR) begin slv_sda = 1'b1; rdmode = ssh[0]; end
                    else sst = SL_IDLE;
                end else if (sst == SL_WR) begin
                    if (wr_n < 16) wr_b[wr_n] = ssh;
                    wr_n++;
                    slv_sda = !force_nack;
                end else slv_sda = 1'b0;
            end else if (bc == 9) begin
                bc = 0; slv_sda = 1'b0;
                if (sst == SL_ADDR) sst = rdmode ? SL_RD : SL_WR;
                else if (sst == SL_RD && !last_ack) sst = SL_IDLE;
                if (sst == SL_RD) begin
                    tx = 8'hC0 + 8'(ld_n); ld_n++; slv_sda = !tx[7];
                end
            end else if (sst == SL_RD) begin
                slv_sda = !tx[7 - bc];
            end
        end
        p_scl = scl_in; p_sda = sda_in;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_data = {op, d};
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin @(negedge clk); n++; end
        if (n >= 20000) check({req, " timeout"}, 1, 0);
    endtask

    task automatic fresh();
        @(negedge clk); flag_clr = 1'b1; clr_req = 1'b1;
        @(negedge clk); flag_clr = 1'b0; clr_req = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 scl_oe", scl_oe, 0); check("R1 sda_oe", sda_oe, 0);
        check("R1 busy", busy, 0); check("R1 rx_valid", rx_valid, 0);
        check("R1 cmd_ready", cmd_ready, 1);
        check("R1 flags", {nack_flag, arb_flag, cmd_err_flag, stop_flag}, 0);
    endtask

    task automatic t_gated_write();
        int n;
        fresh(); bus_idle = 1'b0; mreq_en = 1'b1; mreq = 1'b0;
        push(3'd4, 8'h50); push(3'd0, 8'h3C); push(3'd0, 8'h5A); push(3'd2, 8'h00);
        check("R13 cmd_ready when full", cmd_ready, 0);
        idle_cycles(50); check("R2 bus busy blocks", busy, 0);
        bus_idle = 1'b1; idle_cycles(50); check("R2 mreq low blocks", busy, 0);
        mreq = 1'b1;
        n = 0; while (!busy && n < 100) begin @(negedge clk); n++; end
        n = 0; while (!sda_oe && n < 100) begin n++; @(negedge clk); end
        check("R3 start wait", n, 8);
        check("R3 SCL released at START", scl_oe, 0);
        while (!scl_oe) @(negedge clk);
        while (scl_oe) @(negedge clk);
        n = 0; while (!scl_oe && n < 100) begin n++; @(negedge clk); end
        check("R11 SCL high length", n, 6);
        wait_idle("R3");
        check("R3 bytes written", wr_n, 2);
        check("R3 byte0", wr_b[0], 8'h3C); check("R3 byte1", wr_b[1], 8'h5A);
        check("R12 stop_flag", stop_flag, 1); check("R12 one stop", stops, 1);
        idle_cycles(5); check("R12 flag sticky", stop_flag, 1);
        fresh(); check("R12 flag cleared", stop_flag, 0);
        mreq_en = 1'b0; mreq = 1'b0;
    endtask

    task automatic t_read();
        fresh();
        push(3'd4, 8'h51); push(3'd1, 8'h00); push(3'd1, 8'h00); push(3'd2, 8'h00);
        wait_idle("R4");
        check("R4 ack first", rd_ack[0], 1); check("R4 nack last", rd_ack[1], 0);
        check("R4 rx_valid", rx_valid, 1); check("R4 data0", rx_data, 8'hC0);
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        check("R4 data1", rx_data, 8'hC1);
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        check("R4 rx empty", rx_valid, 0);
    endtask

    task automatic t_restart();
        fresh();
        push(3'd4, 8'h50); push(3'd0, 8'h11); push(3'd4, 8'h51); push(3'd1, 8'h00); push(3'd2, 8'h00);
        wait_idle("R5");
        check("R5 two starts", starts, 2); check("R5 single stop", stops, 1);
        check("R5 written", wr_b[0], 8'h11); check("R5 read data", rx_data, 8'hC0);
        check("R4 lone read nacked", rd_ack[0], 0);
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic t_autostop();
        fresh(); autostop_en = 1'b1;
        push(3'd4, 8'h50); push(3'd0, 8'h22);
        wait_idle("R6");
        check("R6 auto stop", stops, 1); check("R6 byte", wr_b[0], 8'h22);
        fresh(); autostop_en = 1'b0;
        push(3'd4, 8'h50); push(3'd0, 8'h23);
        while (wr_n < 1) @(negedge clk);
        idle_cycles(400);
        check("R6 holds busy", busy, 1); check("R6 holds SCL low", scl_oe, 1);
        check("R6 no stop yet", stops, 0);
        push(3'd2, 8'h00); wait_idle("R6");
        check("R6 stop after push", stops, 1);
    endtask

    task automatic t_disable();
        fresh();
        push(3'd4, 8'h50); push(3'd0, 8'h55); push(3'd0, 8'h66);
        while (!busy) @(negedge clk);
        enable = 1'b0;
        wait_idle("R7");
        check("R7 drained", wr_n, 2); check("R7 last byte", wr_b[1], 8'h66);
        check("R7 stop", stops, 1);
        enable = 1'b1;
    endtask

    task automatic t_nack();
        fresh(); force_nack = 1'b1;
        push(3'd4, 8'h50); push(3'd0, 8'h33); push(3'd0, 8'h44); push(3'd2, 8'h00);
        wait_idle("R8");
        force_nack = 1'b0;
        check("R8 nack_flag", nack_flag, 1); check("R8 one byte", wr_n, 1);
        check("R8 stop", stops, 1);
        idle_cycles(200); check("R8 queue flushed", busy, 0);
    endtask

    task automatic t_arb();
        fresh();
        push(3'd4, 8'h50); push(3'd0, 8'h01); push(3'd2, 8'h00);
        while (!sda_oe) @(negedge clk);
        while (!scl_oe) @(negedge clk);
        rival = 1'b1;
        wait_idle("R9");
        check("R9 arb_flag", arb_flag, 1);
        check("R9 released", {scl_oe, sda_oe}, 0);
        rival = 1'b0;
        idle_cycles(200); check("R9 queue flushed", busy, 0);
        check("R9 nothing written", wr_n, 0);
    endtask

    task automatic t_bad_op();
        fresh();
        push(3'd3, 8'h00); idle_cycles(20);
        check("R10 err flag", cmd_err_flag, 1); check("R10 no activity", busy, 0);
        check("R10 no start", starts, 0);
        fresh();
        push(3'd0, 8'h99); idle_cycles(20);
        check("R10 tx while idle flagged", cmd_err_flag, 1); check("R10 tx while idle no start", starts, 0);
        fresh();
        push(3'd4, 8'h50); push(3'd6, 8'h00); push(3'd0, 8'h77); push(3'd2, 8'h00);
        wait_idle("R10");
        check("R10 mid err flag", cmd_err_flag, 1); check("R10 skip bad", wr_n, 1);
        check("R10 next byte", wr_b[0], 8'h77);
    endtask

    initial begin
        #(200000 * 20);
        nfail++; nchk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        idle_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gated_write();
        t_read();
        t_restart();
        t_autostop();
        t_disable();
        t_nack();
        t_arb();
        t_bad_op();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule